// File: doc/BRIEF.md
# Relative and Absolute Branch Target Resolver

This block chooses the program-counter value that follows a control-flow instruction. The sequencer supplies several inputs: the address of the instruction that sits right after the branch, an 8-bit relative displacement, a full-width absolute destination, the kind of transfer, a 4-bit condition selector and the current N, Z, V, C status bits. The block returns the resolved next PC and a flag saying whether control left the sequential path.

A relative branch adds its displacement, taken as a two's-complement byte, to the sequential address. It does not add it to the address of the branch itself. Conditional relative branches test a single flag or one of the signed comparisons built from N, V and Z that follow a compare. An unconditional relative branch always moves. An absolute jump loads the whole destination with no reach limit.

By default the two outputs are registered, so they appear one clock after the inputs. A parameter makes them purely combinational instead.

Top module: `branch_resolver`

## Requirements
- R1: When a relative transfer is taken, next_pc equals seq_pc plus rel_ofs sign-extended to 16 bits. Displacements 0x00–0x7F move forward and 0x80–0xFF move backward. For example, 0x0009 with 0x03 gives 0x000C, and 0x000F with 0xF7 gives 0x0006.
- R2: Whenever taken is 0, next_pc equals seq_pc.
- R3: With kind = 2 (absolute jump), taken is 1 and next_pc equals abs_target, whatever cond_sel and flags hold.
- R4: With kind = 1 (relative, unconditional), taken is 1 whatever cond_sel and flags hold.
- R5: With kind = 3 (no transfer), taken is 0 and next_pc equals seq_pc.
- R6: With kind = 0 (relative, conditional), the flags are packed as flags[3]=N, flags[2]=Z, flags[1]=V, flags[0]=C. cond_sel 0 branches on C=0, 1 on C=1, 2 on Z=0 and 3 on Z=1.
- R7: With kind = 0, cond_sel 4 branches on N=0, 5 on N=1, 6 on V=0 and 7 on V=1.
- R8: With kind = 0, cond_sel 8 (signed greater-or-equal) branches when N equals V, and cond_sel 9 (signed less-than) branches when N differs from V.
- R9: With kind = 0, cond_sel 10 (signed greater-than) branches when Z=0 and N equals V. cond_sel 11 (signed less-or-equal) branches when Z=1 or N differs from V.
- R10: With kind = 0, cond_sel values 12–15 never branch.
- R11: With REG_OUT = 1, the outputs reflect the inputs present at the previous rising clock edge. A cycle with rst high leaves taken = 0 and next_pc = RESET_PC (0x0000 by default) at the following edge.
- R12: All address arithmetic wraps modulo 2^16. For example, 0xFFFF with 0x01 gives 0x0000, and 0x0010 with 0x80 gives 0xFF90.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| seq_pc | input | 16 | Address of the instruction after the branch |
| rel_ofs | input | 8 | Signed relative displacement |
| abs_target | input | 16 | Absolute jump destination |
| kind | input | 2 | 0 relative conditional, 1 relative unconditional, 2 absolute, 3 none |
| cond_sel | input | 4 | Condition code for kind 0 |
| flags | input | 4 | {N, Z, V, C} status bits |
| next_pc | output | 16 | Resolved next program counter |
| taken | output | 1 | High when control leaves the sequential path |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit displacement and a registered output. With those values every combination of kind, condition code and flag pattern can be swept across four address/displacement/destination vectors. All 256 displacements can also be swept from five sequential addresses that include both wrap boundaries. The expected target is computed as a separate forward add or backward subtract, and the expected decision comes from an independent flag table.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    BK_REL_COND   = 2'd0,
    BK_REL_ALWAYS = 2'd1,
    BK_ABS_JUMP   = 2'd2,
    BK_NONE       = 2'd3
  } br_kind_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;

  localparam logic [3:0] CC_CARRY_CLR = 4'd0;
  localparam logic [3:0] CC_CARRY_SET = 4'd1;
  localparam logic [3:0] CC_NOT_ZERO  = 4'd2;
  localparam logic [3:0] CC_ZERO      = 4'd3;
  localparam logic [3:0] CC_POSITIVE  = 4'd4;
  localparam logic [3:0] CC_NEGATIVE  = 4'd5;
  localparam logic [3:0] CC_NO_OVF    = 4'd6;
  localparam logic [3:0] CC_OVF       = 4'd7;
  localparam logic [3:0] CC_SGE       = 4'd8;
  localparam logic [3:0] CC_SLT       = 4'd9;
  localparam logic [3:0] CC_SGT       = 4'd10;
  localparam logic [3:0] CC_SLE       = 4'd11;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  logic [3:0] cond_sel,
  input  logic [3:0] flags,
  output logic       cond_hit
);
  logic f_n, f_z, f_v, f_c, sign_mismatch;

  assign f_n = flags[FLAG_N];
  assign f_z = flags[FLAG_Z];
  assign f_v = flags[FLAG_V];
  assign f_c = flags[FLAG_C];
  assign sign_mismatch = f_n ^ f_v;

  always_comb begin
    case (cond_sel)
      CC_CARRY_CLR: cond_hit = ~f_c;
      CC_CARRY_SET: cond_hit = f_c;
      CC_NOT_ZERO:  cond_hit = ~f_z;
      CC_ZERO:      cond_hit = f_z;
      CC_POSITIVE:  cond_hit = ~f_n;
      CC_NEGATIVE:  cond_hit = f_n;
      CC_NO_OVF:    cond_hit = ~f_v;
      CC_OVF:       cond_hit = f_v;
      CC_SGE:       cond_hit = ~sign_mismatch;
      CC_SLT:       cond_hit = sign_mismatch;
      CC_SGT:       cond_hit = ~f_z & ~sign_mismatch;
      CC_SLE:       cond_hit = f_z | sign_mismatch;
      default:      cond_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target_adder.sv
module br_target_adder #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [OFS_W-1:0]  rel_ofs,
  output logic [ADDR_W-1:0] rel_target
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;

  assign ofs_ext    = {{EXT_W{rel_ofs[OFS_W-1]}}, rel_ofs};
  assign rel_target = seq_pc + ofs_ext;
endmodule

// File: rtl/br_pc_select.sv
module br_pc_select
  import br_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter bit              REG_OUT  = 1'b1,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        kind,
  input  logic              cond_hit,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [ADDR_W-1:0] rel_target,
  input  logic [ADDR_W-1:0] abs_target,
  output logic [ADDR_W-1:0] next_pc,
  output logic              taken
);
  logic [ADDR_W-1:0] pc_d;
  logic              taken_d;

  always_comb begin
    case (br_kind_e'(kind))
      BK_REL_COND: begin
        taken_d = cond_hit;
        pc_d    = cond_hit ? rel_target : seq_pc;
      end
      BK_REL_ALWAYS: begin
        taken_d = 1'b1;
        pc_d    = rel_target;
      end
      BK_ABS_JUMP: begin
        taken_d = 1'b1;
        pc_d    = abs_target;
      end
      default: begin
        taken_d = 1'b0;
        pc_d    = seq_pc;
      end
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          next_pc <= RESET_PC;
          taken   <= 1'b0;
        end else begin
          next_pc <= pc_d;
          taken   <= taken_d;
        end
      end
    end else begin : g_comb
      assign next_pc = pc_d;
      assign taken   = taken_d;
    end
  endgenerate
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int                ADDR_W   = 16,
  parameter int                OFS_W    = 8,
  parameter bit                REG_OUT  = 1'b1,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [OFS_W-1:0]  rel_ofs,
  input  logic [ADDR_W-1:0] abs_target,
  input  logic [1:0]        kind,
  input  logic [3:0]        cond_sel,
  input  logic [3:0]        flags,
  output logic [ADDR_W-1:0] next_pc,
  output logic              taken
);
  logic              cond_hit;
  logic [ADDR_W-1:0] rel_target;

  br_cond_eval u_cond (
    .cond_sel (cond_sel),
    .flags    (flags),
    .cond_hit (cond_hit)
  );

  br_target_adder #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_add (
    .seq_pc     (seq_pc),
    .rel_ofs    (rel_ofs),
    .rel_target (rel_target)
  );

  br_pc_select #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT), .RESET_PC(RESET_PC)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .kind       (kind),
    .cond_hit   (cond_hit),
    .seq_pc     (seq_pc),
    .rel_target (rel_target),
    .abs_target (abs_target),
    .next_pc    (next_pc),
    .taken      (taken)
  );
endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk #(
  parameter int                ADDR_W   = 16,
  parameter int                OFS_W    = 8,
  parameter bit                REG_OUT  = 1'b1,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] seq_pc,
  input logic [OFS_W-1:0]  rel_ofs,
  input logic [ADDR_W-1:0] abs_target,
  input logic [1:0]        kind,
  input logic [3:0]        cond_sel,
  input logic [3:0]        flags,
  input logic [ADDR_W-1:0] next_pc,
  input logic              taken
);
  logic [ADDR_W-1:0] ofs_wide;
  assign ofs_wide = ADDR_W'($signed(rel_ofs));

  generate
    if (REG_OUT) begin : g_seq
      logic [ADDR_W-1:0] rel_sum_q;
      always_ff @(posedge clk) rel_sum_q <= seq_pc + ofs_wide;

      assert_abs_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind) == 2'd2) |-> (taken && next_pc == $past(abs_target)));
      assert_rel_always_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind) == 2'd1) |-> (taken && next_pc == rel_sum_q));  // R1 as well
      assert_no_transfer_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind) == 2'd3) |-> (!taken && next_pc == $past(seq_pc)));
      assert_fallthrough_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !taken) |-> (next_pc == $past(seq_pc)));
      assert_zero_cond_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind) == 2'd0 && $past(cond_sel) == 4'd3) |-> (taken == $past(flags[2])));
      assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind) == 2'd0 && $past(cond_sel) >= 4'd12) |-> !taken);
      assert_reset_R11: assert property (@(posedge clk)
        $past(rst) |-> (!taken && next_pc == RESET_PC));
    end else begin : g_comb
      assert_abs_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'd2) |-> (taken && next_pc == abs_target));
      assert_rel_always_R4: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'd1) |-> (taken && next_pc == seq_pc + ofs_wide));
      assert_no_transfer_R5: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'd3) |-> (!taken && next_pc == seq_pc));
      assert_fallthrough_R2: assert property (@(posedge clk) disable iff (rst)
        !taken |-> (next_pc == seq_pc));
      assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'd0 && cond_sel >= 4'd12) |-> !taken);
    end
  endgenerate
endmodule

bind branch_resolver br_resolver_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .REG_OUT(REG_OUT), .RESET_PC(RESET_PC)
) u_chk (.*);

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] seq_pc = '0;
  logic [7:0]  rel_ofs = '0;
  logic [15:0] abs_target = '0;
  logic [1:0]  kind = 2'd3;
  logic [3:0]  cond_sel = '0;
  logic [3:0]  flags = '0;
  logic [15:0] next_pc;
  logic        taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_resolver u0 (
    .clk(clk), .rst(rst), .seq_pc(seq_pc), .rel_ofs(rel_ofs),
    .abs_target(abs_target), .kind(kind), .cond_sel(cond_sel),
    .flags(flags), .next_pc(next_pc), .taken(taken)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [1:0] k, input logic [3:0] c, input logic [3:0] f);
    bit n, z, v, cy;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    if (k == 2'd1 || k == 2'd2) return 1'b1;
    if (k == 2'd3) return 1'b0;
    case (c)
      4'd0:  return !cy;
      4'd1:  return cy;
      4'd2:  return !z;
      4'd3:  return z;
      4'd4:  return !n;
      4'd5:  return n;
      4'd6:  return !v;
      4'd7:  return v;
      4'd8:  return n == v;
      4'd9:  return n != v;
      4'd10: return !z && (n == v);
      4'd11: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] rel_dest(input logic [15:0] s, input logic [7:0] o);
    int r;
    if (o < 8'h80) r = int'(s) + int'(o);
    else r = int'(s) - (256 - int'(o));
    return 16'(r & 32'hFFFF);
  endfunction

  function automatic string tag_for(input logic [1:0] k, input logic [3:0] c);
    if (k == 2'd2) return "R3";
    if (k == 2'd1) return "R4";
    if (k == 2'd3) return "R5";
    if (c < 4'd4) return "R6";
    if (c < 4'd8) return "R7";
    if (c < 4'd10) return "R8";
    if (c < 4'd12) return "R9";
    return "R10";
  endfunction

  // Drive at negedge, register captures at posedge, sample at next negedge (R11 latency)
  task automatic step(input logic [15:0] s, input logic [7:0] o, input logic [15:0] a,
                      input logic [1:0] k, input logic [3:0] c, input logic [3:0] f);
    seq_pc = s; rel_ofs = o; abs_target = a; kind = k; cond_sel = c; flags = f;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(input logic [15:0] s, input logic [7:0] o, input logic [15:0] a,
                          input logic [1:0] k, input logic [3:0] c, input logic [3:0] f);
    bit t;
    logic [15:0] ep;
    step(s, o, a, k, c, f);
    t = exp_taken(k, c, f);
    if (!t) ep = s;
    else if (k == 2'd2) ep = a;
    else ep = rel_dest(s, o);
    chk(tag_for(k, c), int'(taken), int'(t));
    chk(t ? ((k == 2'd2) ? "R3" : "R1") : "R2", int'(next_pc), int'(ep));
  endtask

  initial begin
    logic [15:0] vs [4];
    logic [7:0]  vo [4];
    logic [15:0] va [4];
    logic [15:0] sw [5];
    vs[0] = 16'h1234; vo[0] = 8'h10; va[0] = 16'hBEEF;
    vs[1] = 16'h0002; vo[1] = 8'hF0; va[1] = 16'h0000;
    vs[2] = 16'hFFF8; vo[2] = 8'h7F; va[2] = 16'hFFFF;
    vs[3] = 16'h8000; vo[3] = 8'h80; va[3] = 16'h4321;
    sw[0] = 16'h0000; sw[1] = 16'h0009; sw[2] = 16'h000F; sw[3] = 16'h8000; sw[4] = 16'hFFFF;

    // R11: reset state
    seq_pc = 16'h5555; kind = 2'd2; abs_target = 16'hAAAA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset taken", int'(taken), 0);
    chk("R11 reset pc", int'(next_pc), 0);
    rst = 1'b0;

    // R1 / R12 worked examples
    step(16'h0009, 8'h03, 16'h0, 2'd1, 4'd0, 4'd0);
    chk("R1 fwd", int'(next_pc), 16'h000C);
    step(16'h000F, 8'hF7, 16'h0, 2'd1, 4'd0, 4'd0);
    chk("R1 back", int'(next_pc), 16'h0006);
    step(16'hFFFF, 8'h01, 16'h0, 2'd1, 4'd0, 4'd0);
    chk("R12 wrap up", int'(next_pc), 16'h0000);
    step(16'h0010, 8'h80, 16'h0, 2'd1, 4'd0, 4'd0);
    chk("R12 wrap down", int'(next_pc), 16'hFF90);

    // R11 latency: new inputs do not show before the clock edge
    seq_pc = 16'h0100; rel_ofs = 8'h20; kind = 2'd1;
    #1;
    chk("R11 hold pc", int'(next_pc), 16'hFF90);
    @(posedge clk); @(negedge clk);
    chk("R11 update pc", int'(next_pc), 16'h0120);

    // Full sweep of kind x condition x flags
    for (int vi = 0; vi < 4; vi++)
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < 16; c++)
          for (int f = 0; f < 16; f++)
            run_case(vs[vi], vo[vi], va[vi], 2'(k), 4'(c), 4'(f));

    // R1 / R12: every displacement from several bases
    for (int si = 0; si < 5; si++)
      for (int o = 0; o < 256; o++) begin
        step(sw[si], 8'(o), 16'h0, 2'd1, 4'd0, 4'd0);
        chk("R1 R12 sweep", int'(next_pc), int'(rel_dest(sw[si], 8'(o))));
      end

    // R11: reset mid-run clears outputs
    step(16'h2000, 8'h00, 16'h7777, 2'd2, 4'd0, 4'd0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11 mid reset taken", int'(taken), 0);
    chk("R11 mid reset pc", int'(next_pc), 0);
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule